// File: doc/BRIEF.md
# UART Receive Queue with Fill-Level Interrupt

This block is the receive-side store of a memory-mapped serial port. A deserializer offers each received character, together with its error and status bits, on a single-cycle push strobe. A received break is offered with a separate flag. Accepted entries wait in a small circular queue. Each host read of the receive data register takes the oldest entry out of the queue, and the entry appears on the read-data output in the following cycle.

The block drives registered receive-empty, receive-full and receive-interrupt outputs. The interrupt is tied to a programmable fill level. A configuration bit selects one of two modes. In queue mode the full depth is used. In single-register mode the block holds one entry. Whenever that bit changes, the queue is flushed. A push that finds no room is dropped, and the block reports it with a one-cycle overrun strobe.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, rx_empty is 1 and rx_full, rx_irq and rx_overrun are 0.
- R2: With cfg_fifo_en = 1, a push is accepted while fewer than DEPTH (16) entries are held. Entries leave in arrival order. rd_data carries the entry one cycle after the pop_req cycle. If a push and a pop fall in the same cycle, both take effect, and acceptance is judged on the count held before that cycle.
- R3: With cfg_fifo_en = 0, the block holds at most one entry, and a push is accepted only when it is empty.
- R4: A push that is not accepted is dropped. rx_overrun is then 1 for exactly the following cycle, and the held entries stay unchanged.
- R5: A push with push_break = 1 stores an entry with bit 10 set and every other bit zero, whatever push_entry carries.
- R6: rx_empty goes to 0 after an accepted push and goes to 1 after a pop that leaves no entries.
- R7: rx_full goes to 1 when an accepted push fills the current capacity (16 in queue mode, 1 in single-register mode). It goes to 0 after any pop_req cycle that carries no push.
- R8: The trigger is 4 × cfg_rx_level in queue mode. It is 1 when that product is zero or when cfg_fifo_en = 0. rx_irq goes to 1 when a push with no simultaneous pop brings the count to the trigger.
- R9: rx_irq goes to 0 when a pop with no simultaneous push brings the count to the trigger minus one. Other pops leave rx_irq unchanged.
- R10: A cycle in which cfg_fifo_en differs from its previously registered value flushes the queue. The count becomes 0, rx_empty becomes 1, and rx_full, rx_irq and rx_overrun become 0. A push or pop in that cycle is discarded.
- R11: pop_req while the queue is empty changes neither the count nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| cfg_rx_level | input | LVL_W (3) | Receive fill-level select |
| push_valid | input | 1 | One-cycle push from the deserializer |
| push_entry | input | ENTRY_W (12) | Character in bits 7:0, status bits above |
| push_break | input | 1 | Push is a break condition |
| pop_req | input | 1 | Host read of the data register |
| rd_data | output | ENTRY_W (12) | Popped entry, valid the cycle after pop_req |
| rx_empty | output | 1 | Queue holds no entries |
| rx_full | output | 1 | Queue is at its current capacity |
| rx_irq | output | 1 | Receive interrupt request |
| rx_overrun | output | 1 | Strobe for a dropped push |

## Verification
The assertions assume that the configuration inputs change only between push and pop activity. A mode change is allowed to fall in a cycle that also carries a push, because the flush rule defines that case. The assertions also assume that push_entry and push_break are meaningful only while push_valid is high. The stimulus drives every input just after a falling edge, and it returns the push and pop strobes to zero after each step. It changes mode or level in only a small share of random steps, so the queue spends long stretches near full and near the trigger.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic empty;
    logic full;
    logic irq;
    logic ovr;
  } rxq_stat_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int ENTRY_W = 12,
  parameter int DEPTH   = 16,
  parameter int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [PTR_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [PTR_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 3,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] level,
  output logic [CNT_W-1:0] trig
);

  int unsigned raw;

  always_comb begin
    raw = 32'(level) << 2;
    if (!fifo_en || raw == 0)
      trig = CNT_W'(1);
    else if (raw > DEPTH)
      trig = '1;               // never reached by the count
    else
      trig = CNT_W'(raw);
  end

endmodule

// File: rtl/rxq_track.sv
module rxq_track
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_fifo_en,
  input  logic             push_valid,
  input  logic             pop_req,
  input  logic [CNT_W-1:0] trig,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_waddr,
  output logic             mem_re,
  output logic [PTR_W-1:0] mem_raddr,
  output rxq_stat_t        stat
);

  logic             fen_q;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] trig_m1;
  logic             flush;
  logic             push_ok;
  logic             pop_do;

  assign flush   = (fen_q != cfg_fifo_en);
  assign cap     = cfg_fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign push_ok = !flush && push_valid && (count < cap);
  assign pop_do  = !flush && pop_req && (count != '0);
  assign cnt_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_do);
  assign trig_m1 = trig - CNT_W'(1);

  assign mem_we    = push_ok;
  assign mem_waddr = rd_ptr + PTR_W'(count);
  assign mem_re    = pop_req && !flush;
  assign mem_raddr = rd_ptr;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      fen_q      <= cfg_fifo_en;
      rd_ptr     <= '0;
      count      <= '0;
      stat.empty <= 1'b1;
      stat.full  <= 1'b0;
      stat.irq   <= 1'b0;
      stat.ovr   <= 1'b0;
    end else begin
      if (pop_do) rd_ptr <= rd_ptr + PTR_W'(1);
      count      <= cnt_nxt;
      stat.empty <= (cnt_nxt == '0);
      stat.full  <= (cnt_nxt == cap);
      stat.ovr   <= push_valid && !push_ok;
      if (push_ok && !pop_do && cnt_nxt == trig)
        stat.irq <= 1'b1;
      else if (pop_do && !push_ok && cnt_nxt == trig_m1)
        stat.irq <= 1'b0;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R2
  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fifo_en && !flush) |-> count <= CNT_W'(1)); // R3
  AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (push_valid && stat.full && !flush && fen_q == cfg_fifo_en) |=> stat.ovr); // R4
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_valid && stat.empty && !flush) |=> stat.empty); // R11
  AST_FULL_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_valid && !flush) |=> !stat.full); // R7
  AST_TRIG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    trig != '0); // R8
  AST_IRQ_RISE_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
    $rose(stat.irq) |-> $past(push_valid)); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (stat.empty && !stat.full && !stat.irq && !stat.ovr)); // R10

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 12,
  parameter int BRK_BIT = 10,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_fifo_en,
  input  logic [LVL_W-1:0]   cfg_rx_level,
  input  logic               push_valid,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               push_break,
  input  logic               pop_req,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rx_empty,
  output logic               rx_full,
  output logic               rx_irq,
  output logic               rx_overrun
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ENTRY_W-1:0] BRK_WORD = ENTRY_W'(1) << BRK_BIT;

  logic [CNT_W-1:0]   trig;
  logic               mem_we;
  logic               mem_re;
  logic [PTR_W-1:0]   mem_waddr;
  logic [PTR_W-1:0]   mem_raddr;
  logic [ENTRY_W-1:0] wdata;
  rxq_stat_t          stat;

  assign wdata = push_break ? BRK_WORD : push_entry;

  rxq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_level (
    .fifo_en (cfg_fifo_en),
    .level   (cfg_rx_level),
    .trig    (trig)
  );

  rxq_track #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .cfg_fifo_en (cfg_fifo_en),
    .push_valid  (push_valid),
    .pop_req     (pop_req),
    .trig        (trig),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_re      (mem_re),
    .mem_raddr   (mem_raddr),
    .stat        (stat)
  );

  rxq_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

  assign rx_empty   = stat.empty;
  assign rx_full    = stat.full;
  assign rx_irq     = stat.irq;
  assign rx_overrun = stat.ovr;

  AST_BREAK_WORD: assert property (@(posedge clk) disable iff (rst)
    (push_valid && push_break) |-> wdata == BRK_WORD); // R5

endmodule

// File: tb/uart_rx_queue_bench.sv
module uart_rx_queue_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_fifo_en;
  logic [2:0]  cfg_rx_level;
  logic        push_valid;
  logic [11:0] push_entry;
  logic        push_break;
  logic        pop_req;
  logic [11:0] rd_data;
  logic        rx_empty, rx_full, rx_irq, rx_overrun;

  always #5 clk = ~clk;

  uart_rx_queue u_uart_rx_queue (
    .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .cfg_rx_level(cfg_rx_level),
    .push_valid(push_valid), .push_entry(push_entry), .push_break(push_break),
    .pop_req(pop_req), .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [11:0] mq [16];
  int          mrp, mcnt;
  bit          mfen_q, mempty, mfull, mirq, movr, rdchk;
  logic [11:0] mrd;

  function automatic int trig_of(bit fen, logic [2:0] lvl);
    if (!fen || lvl == 0) return 1;
    return 4 * int'(lvl);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit push, bit brk, logic [11:0] d, bit pop);
    int cap, trig, nc;
    bit push_ok, pop_do;
    rdchk = 0;
    if (cfg_fifo_en != mfen_q) begin
      mfen_q = cfg_fifo_en; mcnt = 0; mrp = 0;
      mempty = 1; mfull = 0; mirq = 0; movr = 0;
      return;
    end
    cap     = cfg_fifo_en ? 16 : 1;
    trig    = trig_of(cfg_fifo_en, cfg_rx_level);
    push_ok = push && (mcnt < cap);
    pop_do  = pop && (mcnt != 0);
    if (pop) begin
      mrd   = mq[mrp];
      rdchk = pop_do;
    end
    if (push_ok) mq[(mrp + mcnt) % 16] = brk ? 12'h400 : d;
    if (pop_do) mrp = (mrp + 1) % 16;
    nc = mcnt + int'(push_ok) - int'(pop_do);
    if (push_ok && !pop_do && nc == trig) mirq = 1;
    else if (pop_do && !push_ok && nc == trig - 1) mirq = 0;
    mempty = (nc == 0);
    mfull  = (nc == cap);
    movr   = push && !push_ok;
    mcnt   = nc;
  endtask

  task automatic step(string tag, bit push, bit brk, logic [11:0] d, bit pop);
    push_valid = push; push_break = brk; push_entry = d; pop_req = pop;
    @(posedge clk);
    model_step(push, brk, d, pop);
    @(negedge clk);
    push_valid = 0; push_break = 0; pop_req = 0;
    chk(tag, "R6 rx_empty", 32'(rx_empty), 32'(mempty));
    chk(tag, "R7 rx_full", 32'(rx_full), 32'(mfull));
    chk(tag, "R8/R9 rx_irq", 32'(rx_irq), 32'(mirq));
    chk(tag, "R4 rx_overrun", 32'(rx_overrun), 32'(movr));
    if (rdchk) chk(tag, "R2 rd_data", 32'(rd_data), 32'(mrd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; cfg_fifo_en = 1; cfg_rx_level = 3'd1;
    push_valid = 0; push_entry = '0; push_break = 0; pop_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mfen_q = 1; mcnt = 0; mrp = 0; mempty = 1; mfull = 0; mirq = 0; movr = 0;
    chk("R1", "rx_empty", 32'(rx_empty), 32'd1);
    chk("R1", "rx_full", 32'(rx_full), 32'd0);
    chk("R1", "rx_irq", 32'(rx_irq), 32'd0);
    chk("R1", "rx_overrun", 32'(rx_overrun), 32'd0);

    // queue mode, trigger 4: fill, overrun, drain in order
    for (int i = 0; i < 16; i++) step("R8", 1, 0, 12'(12'h030 + i), 0);
    step("R4", 1, 0, 12'h0EE, 0);
    for (int i = 0; i < 16; i++) step("R9", 0, 0, '0, 1);
    step("R11", 0, 0, '0, 1);
    step("R11", 0, 0, '0, 1);

    // break entry
    step("R5", 1, 1, 12'h0FF, 0);
    step("R5", 0, 0, '0, 1);

    // simultaneous push and pop
    step("R2", 1, 0, 12'h111, 0);
    step("R2", 1, 0, 12'h222, 1);
    step("R2", 0, 0, '0, 1);

    // partial fill then mode change flushes
    for (int i = 0; i < 5; i++) step("R10", 1, 0, 12'(12'h050 + i), 0);
    cfg_fifo_en = 0;
    step("R10", 1, 0, 12'h077, 0);
    step("R11", 0, 0, '0, 1);

    // single-register mode
    step("R3", 1, 0, 12'h0A5, 0);
    step("R3", 1, 0, 12'h05A, 0);
    step("R3", 0, 0, '0, 1);
    step("R3", 1, 0, 12'h0C3, 1);
    step("R3", 0, 0, '0, 1);

    // back to queue mode, level 0 -> trigger 1
    cfg_fifo_en = 1; cfg_rx_level = 3'd0;
    step("R10", 0, 0, '0, 0);
    step("R8", 1, 0, 12'h012, 0);
    step("R9", 0, 0, '0, 1);

    // level 4 -> trigger 16
    cfg_rx_level = 3'd4;
    for (int i = 0; i < 16; i++) step("R8", 1, 0, 12'(i), 0);
    step("R9", 0, 0, '0, 1);
    for (int i = 0; i < 15; i++) step("R2", 0, 0, '0, 1);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      bit p, b, q;
      if ($urandom_range(0, 99) < 1) cfg_fifo_en = ~cfg_fifo_en;
      if ($urandom_range(0, 99) < 3) cfg_rx_level = 3'($urandom_range(0, 7));
      p = ($urandom_range(0, 99) < 50);
      b = p && ($urandom_range(0, 9) == 0);
      q = ($urandom_range(0, 99) < 40);
      step("R2", p, b, 12'($urandom), q);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule